// File: doc/BRIEF.md
# Memory Access Wait-State Inserter

This block sits beside an 8-bit Z80-style CPU on its memory bus. It lengthens individual memory accesses by one clock cycle. It watches the active-low bus strobes (MREQ, M1, RD, WR) and a region input that says whether the current access targets flash or RAM. From these it sorts each access into one of three kinds: opcode fetch, data read or write. If the matching enable bit is set, it pulls its active-low WAIT output low for exactly one clock, so the CPU inserts a single wait state.

Two small registers hold the policy, and software reaches them through an I/O-style port.
- The delay-select register holds one bit per region and access kind.
- The group-enable register switches the whole flash group and the whole RAM group on or off.

An instruction that makes several memory accesses is slowed by one clock for each access that qualifies. This includes stack pushes and pops. I/O port cycles, which run without MREQ, are never stretched.

Top module: `memwait_ctrl`

## Requirements
- R1: An access with MREQ, M1 and RD all low is an opcode fetch. A flash opcode fetch gets one wait clock when delay-select bit 0 is set.
- R2: An access with MREQ and RD low and M1 high is a data read. An access with MREQ and WR low is a write. Flash data reads use delay-select bit 1 and flash writes use bit 2.
- R3: RAM accesses use delay-select bit 4 for opcode fetches, bit 5 for data reads and bit 6 for writes. The region input is 1 for flash and 0 for RAM.
- R4: Delay-select bits 3 and 7 are stored and read back exactly as written, and they have no effect on timing.
- R5: After reset, the delay-select register (register address 0) reads 0x44 and the group-enable register (address 1) reads 0x00. Group-enable bits 7:2 always read as 0.
- R6: A qualifying access is stretched by exactly one clock. WAIT is low for a single cycle, and it goes low at most once while MREQ stays low.
- R7: No wait is inserted when MREQ is high, even if RD or WR is low (an I/O cycle).
- R8: Flash delays apply only while group-enable bit 0 is 1, and RAM delays apply only while group-enable bit 1 is 1.
- R9: A register write applies to every access that starts after it. In a sequence of accesses, the extra clocks add up to the number of qualifying accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mreq_ni | input | 1 | Memory request strobe, active low |
| m1_ni | input | 1 | Opcode-fetch cycle marker, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| flash_sel_i | input | 1 | Region of the current access: 1 = flash, 0 = RAM |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 = delay-select, 1 = group-enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read-back of the selected register |
| wait_no | output | 1 | Wait request to the CPU, active low |

## Verification
The assertions assume two things about the bus. First, MREQ goes high for at least one clock between two memory accesses. Second, RD and WR are never low at the same time. They also assume the registers are not rewritten while an access is under way. The bench keeps within these rules: it drives every machine cycle as one strobe pattern held for the base T-state count, follows it with one idle clock, and issues register writes only in idle time. For each emulated access or instruction, the bench counts clocks and compares the count with the base T-states plus the penalties it derives from its own copy of the register values.

// File: rtl/memwait_pkg.sv
package memwait_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  localparam int NUM_KINDS  = 3;
  localparam int FLASH_LSB  = 0;
  localparam int RAM_LSB    = 4;
  localparam int GRP_FLASH  = 0;
  localparam int GRP_RAM    = 1;
endpackage

// File: rtl/memwait_regs.sv
module memwait_regs #(
  parameter int           DATA_W  = 8,
  parameter int           EN_W    = 2,
  parameter logic [7:0]   CFG_RST = 8'h44,
  parameter logic [1:0]   EN_RST  = 2'b00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [EN_W-1:0]   en_o
);
  localparam int PAD_W = DATA_W - EN_W;

  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic [EN_W-1:0]   en_q, en_d;
  logic              cfg_load, en_load;

  always_comb begin
    cfg_load = we_i && !addr_i;
    en_load  = we_i &&  addr_i;
    cfg_d    = cfg_load ? wdata_i : cfg_q;
    en_d     = en_load  ? wdata_i[EN_W-1:0] : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= DATA_W'(CFG_RST);
      en_q  <= EN_W'(EN_RST);
    end else begin
      cfg_q <= cfg_d;
      en_q  <= en_d;
    end
  end

  assign rdata_o = addr_i ? {{PAD_W{1'b0}}, en_q} : cfg_q;
  assign cfg_o   = cfg_q;
  assign en_o    = en_q;

  // R4: every bit, reserved ones included, is stored as written
  a_r4_cfg_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i) |=> (cfg_q == $past(wdata_i)));

  // R9: registers hold their value when not written
  a_r9_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(en_q) && $stable(cfg_q)));
endmodule

// File: rtl/memwait_classify.sv
module memwait_classify
  import memwait_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EN_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mreq_ni,
  input  logic              m1_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              flash_i,
  input  logic [DATA_W-1:0] cfg_i,
  input  logic [EN_W-1:0]   en_i,
  output acc_kind_e         kind_o,
  output logic              strobe_o,
  output logic              hit_o
);
  logic [3:0] flash_mask, ram_mask;
  logic       sel_bit;

  assign flash_mask[3] = 1'b0;
  assign ram_mask[3]   = 1'b0;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    assign flash_mask[k] = cfg_i[FLASH_LSB + k];
    assign ram_mask[k]   = cfg_i[RAM_LSB + k];
  end

  always_comb begin
    if (mreq_ni)     kind_o = ACC_NONE;
    else if (!wr_ni) kind_o = ACC_WRITE;
    else if (!rd_ni) kind_o = m1_ni ? ACC_READ : ACC_FETCH;
    else             kind_o = ACC_NONE;
  end

  always_comb begin
    if (flash_i) sel_bit = en_i[GRP_FLASH] && flash_mask[kind_o];
    else         sel_bit = en_i[GRP_RAM]   && ram_mask[kind_o];
  end

  assign strobe_o = (kind_o != ACC_NONE);
  assign hit_o    = strobe_o && sel_bit;

  // R7: a cycle without MREQ never produces a hit
  a_r7_io_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_ni |-> !hit_o);
endmodule

// File: rtl/memwait_stretch.sv
module memwait_stretch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mreq_ni,
  input  logic strobe_i,
  input  logic hit_i,
  output logic wait_no
);
  logic served_q, served_d;
  logic wait_q, wait_d;
  logic qualify;

  always_comb begin
    qualify  = strobe_i && !served_q;
    served_d = mreq_ni ? 1'b0 : (served_q || strobe_i);
    wait_d   = !(qualify && hit_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      served_q <= 1'b0;
      wait_q   <= 1'b1;
    end else begin
      served_q <= served_d;
      wait_q   <= wait_d;
    end
  end

  assign wait_no = wait_q;

  // R6: the wait request lasts one clock only
  a_r6_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_q |=> wait_q);

  // R6: no second wait while the same MREQ stays low
  a_r6_once_per_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_q && !mreq_ni) |=> (wait_q && (mreq_ni || served_q)));

  // R7: a wait always follows a cycle with MREQ low
  a_r7_needs_mreq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_q |-> $past(!mreq_ni));
endmodule

// File: rtl/memwait_ctrl.sv
module memwait_ctrl
  import memwait_pkg::*;
#(
  parameter int         DATA_W  = 8,
  parameter int         EN_W    = 2,
  parameter logic [7:0] CFG_RST = 8'h44,
  parameter logic [1:0] EN_RST  = 2'b00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mreq_ni,
  input  logic              m1_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              flash_sel_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              wait_no
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [DATA_W-1:0] cfg;
  logic [EN_W-1:0]   en;
  acc_kind_e         kind;
  logic              strobe, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  memwait_regs #(.DATA_W(DATA_W), .EN_W(EN_W), .CFG_RST(CFG_RST), .EN_RST(EN_RST)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .cfg_o(cfg), .en_o(en)
  );

  memwait_classify #(.DATA_W(DATA_W), .EN_W(EN_W)) u_classify (
    .clk_i(clk_i), .rst_ni(rst_n), .mreq_ni(mreq_ni), .m1_ni(m1_ni),
    .rd_ni(rd_ni), .wr_ni(wr_ni), .flash_i(flash_sel_i), .cfg_i(cfg),
    .en_i(en), .kind_o(kind), .strobe_o(strobe), .hit_o(hit)
  );

  memwait_stretch u_stretch (
    .clk_i(clk_i), .rst_ni(rst_n), .mreq_ni(mreq_ni),
    .strobe_i(strobe), .hit_i(hit), .wait_no(wait_no)
  );

  // R8: a wait implies the group enable of the sampled region was set
  a_r8_group_gate: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wait_no |-> ($past(flash_sel_i) ? $past(en[GRP_FLASH]) : $past(en[GRP_RAM])));
endmodule

// File: tb/memwait_ctrl_tb_top.sv
module memwait_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mreq_n, m1_n, rd_n, wr_n, flash;
  logic       we, addr;
  logic [7:0] wdata, rdata;
  logic       wait_n;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;
  logic [7:0] cfg_sh;
  logic [1:0] en_sh;

  localparam int K_FETCH = 0, K_READ = 1, K_WRITE = 2;

  always #2 clk = ~clk; // 250 MHz

  memwait_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mreq_ni(mreq_n), .m1_ni(m1_n), .rd_ni(rd_n),
    .wr_ni(wr_n), .flash_sel_i(flash), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wait_no(wait_n)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int penalty(input int kind, input logic fl);
    if (fl) return (en_sh[0] && cfg_sh[kind]) ? 1 : 0;
    return (en_sh[1] && cfg_sh[4 + kind]) ? 1 : 0;
  endfunction

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 1'b0;
    if (a) en_sh = d[1:0]; else cfg_sh = d;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
    addr = 1'b0;
  endtask

  // one machine cycle; returns clocks used and number of wait clocks seen
  task automatic do_acc(input int kind, input logic fl, output int clocks, output int waits);
    int limit;
    limit  = (kind == K_FETCH) ? 4 : 3;
    clocks = 0;
    waits  = 0;
    @(negedge clk);
    mreq_n = 1'b0;
    m1_n   = (kind == K_FETCH) ? 1'b0 : 1'b1;
    rd_n   = (kind == K_WRITE) ? 1'b1 : 1'b0;
    wr_n   = (kind == K_WRITE) ? 1'b0 : 1'b1;
    flash  = fl;
    while (clocks < limit) begin
      @(negedge clk);
      clocks++;
      if (!wait_n) begin
        waits++;
        limit++;
      end
    end
    mreq_n = 1'b1; m1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_acc(input string tag, input int kind, input logic fl);
    int c, w, base;
    base = (kind == K_FETCH) ? 4 : 3;
    do_acc(kind, fl, c, w);
    check(tag, c, base + penalty(kind, fl));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R6 reset wait high", int'(wait_n), 1);
    reg_read(1'b0, d);
    check("R5 cfg reset 0x44", int'(d), 'h44);
    reg_read(1'b1, d);
    check("R5 enable reset 0x00", int'(d), 0);
    check_acc("R8 reset flash write no delay", K_WRITE, 1'b1);
  endtask

  task automatic t_flash();
    reg_write(1'b1, 8'h01);
    reg_write(1'b0, 8'h01);
    check_acc("R1 flash fetch delayed", K_FETCH, 1'b1);
    check_acc("R1 flash read undelayed", K_READ, 1'b1);
    check_acc("R1 ram fetch undelayed", K_FETCH, 1'b0);
    reg_write(1'b0, 8'h02);
    check_acc("R2 flash read delayed", K_READ, 1'b1);
    check_acc("R2 flash fetch undelayed", K_FETCH, 1'b1);
    reg_write(1'b0, 8'h04);
    check_acc("R2 flash write delayed", K_WRITE, 1'b1);
    check_acc("R2 flash read undelayed", K_READ, 1'b1);
  endtask

  task automatic t_ram();
    reg_write(1'b1, 8'h02);
    reg_write(1'b0, 8'h10);
    check_acc("R3 ram fetch delayed", K_FETCH, 1'b0);
    check_acc("R3 ram write undelayed", K_WRITE, 1'b0);
    reg_write(1'b0, 8'h20);
    check_acc("R3 ram read delayed", K_READ, 1'b0);
    check_acc("R3 flash read undelayed", K_READ, 1'b1);
    reg_write(1'b0, 8'h40);
    check_acc("R3 ram write delayed", K_WRITE, 1'b0);
    check_acc("R3 ram fetch undelayed", K_FETCH, 1'b0);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    reg_write(1'b1, 8'h03);
    reg_write(1'b0, 8'h88);
    reg_read(1'b0, d);
    check("R4 reserved bits read back", int'(d), 'h88);
    check_acc("R4 reserved bits no flash delay", K_WRITE, 1'b1);
    check_acc("R4 reserved bits no ram delay", K_READ, 1'b0);
    reg_write(1'b1, 8'hFF);
    reg_read(1'b1, d);
    check("R5 enable upper bits read 0", int'(d), 3);
  endtask

  task automatic t_single();
    int c, w;
    reg_write(1'b1, 8'h03);
    reg_write(1'b0, 8'h77);
    do_acc(K_READ, 1'b0, c, w);
    check("R6 one wait clock per access", w, 1);
    check("R6 access length base+1", c, 4);
  endtask

  task automatic t_io();
    int waits;
    waits = 0;
    @(negedge clk);
    rd_n = 1'b0; m1_n = 1'b1; flash = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!wait_n) waits++;
    end
    rd_n = 1'b1; wr_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!wait_n) waits++;
    end
    wr_n = 1'b1;
    @(negedge clk);
    if (!wait_n) waits++;
    check("R7 io cycles never wait", waits, 0);
  endtask

  task automatic t_gate();
    reg_write(1'b0, 8'h77);
    reg_write(1'b1, 8'h00);
    check_acc("R8 flash gated off", K_FETCH, 1'b1);
    check_acc("R8 ram gated off", K_WRITE, 1'b0);
    reg_write(1'b1, 8'h01);
    check_acc("R8 flash group on", K_READ, 1'b1);
    check_acc("R8 ram group still off", K_READ, 1'b0);
    reg_write(1'b1, 8'h02);
    check_acc("R8 flash group off", K_WRITE, 1'b1);
    check_acc("R8 ram group on", K_FETCH, 1'b0);
  endtask

  // emulated instructions: list of access kinds in one region
  task automatic run_seq(input string tag, input int kinds[], input logic fl);
    int total, exp, c, w;
    total = 0; exp = 0;
    foreach (kinds[i]) begin
      do_acc(kinds[i], fl, c, w);
      total += c;
      exp   += ((kinds[i] == K_FETCH) ? 4 : 3) + penalty(kinds[i], fl);
    end
    check(tag, total, exp);
  endtask

  task automatic t_sequence();
    int ld_abs[]  = '{K_FETCH, K_READ, K_READ, K_READ};
    int push_op[] = '{K_FETCH, K_WRITE, K_WRITE};
    int ldi_op[]  = '{K_FETCH, K_FETCH, K_READ, K_WRITE};
    reg_write(1'b1, 8'h03);
    reg_write(1'b0, 8'h44);
    run_seq("R9 push ram write delays", push_op, 1'b0);
    reg_write(1'b0, 8'h30);
    run_seq("R9 load absolute ram fetch+read", ld_abs, 1'b0);
    reg_write(1'b0, 8'h07);
    run_seq("R9 block move flash all kinds", ldi_op, 1'b1);
    reg_write(1'b0, 8'h00);
    run_seq("R9 new cfg applies next access", ldi_op, 1'b1);
  endtask

  initial begin
    mreq_n = 1'b1; m1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; flash = 1'b0;
    we = 1'b0; addr = 1'b0; wdata = '0;
    cfg_sh = 8'h44; en_sh = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_flash();
    t_ram();
    t_reserved();
    t_single();
    t_io();
    t_gate();
    t_sequence();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule